// File: doc/BRIEF.md
# LCD vertical frame timing sequencer

This block produces the vertical timing of an LCD frame. Its time base is the line period, marked by a one-cycle `line_tick` pulse from the horizontal timing logic. Each frame runs through fixed phases: a beginning-of-frame wait, the display lines, an end-of-frame wait and a vertical sync pulse on the frame-clock pin. The outputs are the frame clock, a gate that lets the line clock toggle, a flag marking pixel-carrying lines, the index of the current line and a one-cycle end-of-frame strobe.

Two panel styles are supported. For active panels the frame clock acts as vertical sync, and the line clock keeps running through both waits. For passive panels the sync-width field sets a count of inserted line periods after the display lines, during which the line clock is held. In that mode the frame clock is a single line period long and marks the first line. The four programmed fields are captured when `en` rises and are held until the block is disabled.

Top module: `lcd_vtiming_seq`

## Requirements
- R1: A frame has `lines_m1`+1 display lines. `line_valid` is high only during them, and `line_idx` counts 0 up to `lines_m1` across them. `line_idx` is 0 at every other time.
- R2: Active mode (`active_mode`=1) repeats this order of line periods: `bof_wait` wait periods, the display lines, `eof_wait` wait periods, then `sync_m1`+1 periods with `frame_clk` high. `frame_clk` is low at all other times.
- R3: In active mode, `line_clk_gate` is high in every line period of the frame, the waits included.
- R4: Passive mode (`active_mode`=0) inserts `sync_m1`+1 line periods after the display lines. During them `line_clk_gate`, `line_valid` and `frame_clk` are all low. Display lines are next.
- R5: In passive mode, `frame_clk` is high for exactly the first display line period of each frame. `eof_wait` and `bof_wait` have no effect.
- R6: The programmed fields and the mode selects are captured in the cycle where `en` rises. Changes to them while `en` stays high have no effect.
- R7: With `en` low, all outputs are 0 one cycle later. This holds even when a line tick arrives in the same cycle. After `en` rises, all outputs stay 0 until the first `line_tick`, and the first frame starts with that tick. Outputs update in the cycle after the clock edge that samples a tick.
- R8: `frame_done` is high for exactly one cycle, the cycle after the tick that ends the last display line. The spacing between two strobes equals the frame length in line periods.
- R9: `dual_panel` does not change the sequence. `lines_m1` counts the lines of one panel in both settings.
- R10: A wait field of 0 removes that wait. With `eof_wait`=0, sync starts in the line period right after the last display line. With `bof_wait`=0, display starts right after sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Sequencer enable; rising edge captures the fields |
| line_tick | input | 1 | One-cycle pulse marking each line period |
| active_mode | input | 1 | 1 = active panel, 0 = passive panel |
| dual_panel | input | 1 | Dual-panel select |
| lines_m1 | input | 10 | Lines per panel minus one |
| sync_m1 | input | 6 | Sync width (active) or inserted periods (passive), minus one |
| eof_wait | input | 8 | End-of-frame wait in line periods (active only) |
| bof_wait | input | 8 | Beginning-of-frame wait in line periods (active only) |
| frame_clk | output | 1 | Frame clock / vertical sync pin |
| line_clk_gate | output | 1 | High while the line clock may toggle |
| line_valid | output | 1 | Current line period carries pixels |
| line_idx | output | 10 | Display line index within the panel |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
Two events can land in the same cycle: the end-of-frame strobe and the phase change out of the display lines. With `eof_wait`=0 in active mode, that change starts the sync pulse. The bench provokes this with vectors that use a zero end wait, a single display line and a one-period sync. It then requires `frame_done` and `frame_clk` to be high at the same sample, with `line_valid` already low. A second pairing is a line tick arriving in the same cycle that `en` falls. The bench drives this and expects the idle state, not an advanced phase.

// File: rtl/lcd_vt_pkg.sv
// Package: shared widths, phase encoding and captured-configuration type
// for the LCD vertical timing sequencer.
package lcd_vt_pkg;

    localparam int LPP_W  = 10;
    localparam int VSW_W  = 6;
    localparam int WAIT_W = 8;
    localparam int CNT_W  = (LPP_W > WAIT_W) ? ((LPP_W > VSW_W) ? LPP_W : VSW_W)
                                             : ((WAIT_W > VSW_W) ? WAIT_W : VSW_W);

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ARM  = 3'd1,
        PH_BOFW = 3'd2,
        PH_DISP = 3'd3,
        PH_EOFW = 3'd4,
        PH_SYNC = 3'd5,
        PH_INS  = 3'd6
    } phase_t;

    typedef struct packed {
        logic              active;
        logic              dual;
        logic [LPP_W-1:0]  lpp;
        logic [VSW_W-1:0]  vsw;
        logic [WAIT_W-1:0] efw;
        logic [WAIT_W-1:0] bfw;
    } cfg_t;

endpackage

// File: rtl/lcd_vt_cfg.sv
// Configuration capture. The programmed fields are latched in the cycle
// where en rises. Passive mode stores both waits as zero.
// Assumes en is synchronous to clk.
module lcd_vt_cfg
    import lcd_vt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  cfg_t cfg_in,
    output cfg_t cfg_q,
    output logic start
);

    logic en_q;

    assign start = en && !en_q;

    // Track enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Capture fields on enable rise; passive mode forces waits to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (start) begin
            cfg_q     <= cfg_in;
            if (!cfg_in.active) begin
                cfg_q.efw <= '0;
                cfg_q.bfw <= '0;
            end
        end
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_q) |=> $stable(cfg_q));

endmodule

// File: rtl/lcd_vt_phase.sv
// Phase sequencer. Walks the frame phases one line tick at a time.
// Zero-length waits are skipped. Assumes cfg is stable while en is high.
module lcd_vt_phase
    import lcd_vt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             tick,
    input  cfg_t             cfg,
    output phase_t           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             eof
);

    logic [CNT_W-1:0] limit;
    phase_t           nxt;
    logic             at_end;

    // Last count value of the current phase.
    always_comb begin
        case (phase)
            PH_DISP: limit = CNT_W'(cfg.lpp);
            PH_BOFW: limit = CNT_W'(cfg.bfw) - CNT_W'(1);
            PH_EOFW: limit = CNT_W'(cfg.efw) - CNT_W'(1);
            PH_SYNC,
            PH_INS:  limit = CNT_W'(cfg.vsw);
            default: limit = '0;
        endcase
    end

    assign at_end = (cnt == limit);

    // Successor phase, skipping empty waits.
    always_comb begin
        case (phase)
            PH_ARM:  nxt = (cfg.active && cfg.bfw != '0) ? PH_BOFW : PH_DISP;
            PH_BOFW: nxt = PH_DISP;
            PH_DISP: nxt = !cfg.active ? PH_INS :
                           (cfg.efw != '0) ? PH_EOFW : PH_SYNC;
            PH_EOFW: nxt = PH_SYNC;
            PH_SYNC: nxt = (cfg.bfw != '0) ? PH_BOFW : PH_DISP;
            PH_INS:  nxt = PH_DISP;
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase/count register with end-of-frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            eof   <= 1'b0;
        end else begin
            eof <= 1'b0;
            if (!en) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else if (start) begin
                phase <= PH_ARM;
                cnt   <= '0;
            end else if (tick && phase != PH_IDLE) begin
                if (phase == PH_ARM || at_end) begin
                    phase <= nxt;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                if (phase == PH_DISP && at_end) eof <= 1'b1;
            end
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && phase != PH_ARM) |-> (cnt <= limit));

    // R8
    eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);

    // R8
    eof_after_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> (phase != PH_DISP));

endmodule

// File: rtl/lcd_vt_out.sv
// Output decode. Maps the phase and count onto the panel pins for the
// selected mode. Purely combinational apart from its assertions.
module lcd_vt_out
    import lcd_vt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  phase_t           phase,
    input  logic [CNT_W-1:0] cnt,
    output logic             fclk,
    output logic             lclk_gate,
    output logic             valid,
    output logic [LPP_W-1:0] idx
);

    // Frame clock: sync phase (active) or first display line (passive).
    always_comb begin
        if (active) fclk = (phase == PH_SYNC);
        else        fclk = (phase == PH_DISP) && (cnt == '0);
    end

    // Line clock runs in every frame phase except passive insertion.
    always_comb begin
        case (phase)
            PH_BOFW, PH_DISP, PH_EOFW, PH_SYNC: lclk_gate = 1'b1;
            default:                            lclk_gate = 1'b0;
        endcase
    end

    // Display-line flag and index.
    always_comb begin
        valid = (phase == PH_DISP);
        idx   = valid ? cnt[LPP_W-1:0] : '0;
    end

    // R4
    gate_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lclk_gate |-> !valid);

    // R2
    sync_vs_pixels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fclk) |-> !valid);

endmodule

// File: rtl/lcd_vtiming_seq.sv
// Top: LCD vertical frame timing sequencer. Counts line ticks through
// the wait, display and sync phases. Fields are captured on enable rise.
// Assumes line_tick is a one-cycle pulse synchronous to clk.
module lcd_vtiming_seq
    import lcd_vt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              line_tick,
    input  logic              active_mode,
    input  logic              dual_panel,
    input  logic [LPP_W-1:0]  lines_m1,
    input  logic [VSW_W-1:0]  sync_m1,
    input  logic [WAIT_W-1:0] eof_wait,
    input  logic [WAIT_W-1:0] bof_wait,
    output logic              frame_clk,
    output logic              line_clk_gate,
    output logic              line_valid,
    output logic [LPP_W-1:0]  line_idx,
    output logic              frame_done
);

    cfg_t             cfg_in;
    cfg_t             cfg_q;
    logic             start;
    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    // Bundle the field inputs.
    always_comb begin
        cfg_in.active = active_mode;
        cfg_in.dual   = dual_panel;
        cfg_in.lpp    = lines_m1;
        cfg_in.vsw    = sync_m1;
        cfg_in.efw    = eof_wait;
        cfg_in.bfw    = bof_wait;
    end

    lcd_vt_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .start  (start)
    );

    lcd_vt_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .start (start),
        .tick  (line_tick),
        .cfg   (cfg_q),
        .phase (phase),
        .cnt   (cnt),
        .eof   (frame_done)
    );

    lcd_vt_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (cfg_q.active),
        .phase     (phase),
        .cnt       (cnt),
        .fclk      (frame_clk),
        .lclk_gate (line_clk_gate),
        .valid     (line_valid),
        .idx       (line_idx)
    );

    // R7
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!frame_clk && !line_clk_gate && !line_valid && line_idx == '0 && !frame_done));

    // R7
    arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) && !line_tick) |=> (!line_clk_gate && !frame_clk && !line_valid));

endmodule

// File: tb/sim_lcd_vtiming_seq.sv
module sim_lcd_vtiming_seq;

    localparam int CLK_P = 10;
    localparam int NROW  = 8;

    typedef struct packed {
        logic        act;
        logic        dual;
        logic [9:0]  lpp;
        logic [5:0]  vsw;
        logic [7:0]  efw;
        logic [7:0]  bfw;
        logic [11:0] flen;
    } row_t;

    // Stimulus and expected frame length in line periods.
    localparam row_t TAB [NROW] = '{
        '{1'b1, 1'b0, 10'd3,    6'd1,  8'd2,   8'd1,   12'd9},
        '{1'b1, 1'b0, 10'd0,    6'd0,  8'd0,   8'd0,   12'd2},
        '{1'b1, 1'b1, 10'd3,    6'd1,  8'd2,   8'd1,   12'd9},
        '{1'b0, 1'b0, 10'd4,    6'd2,  8'd5,   8'd3,   12'd8},
        '{1'b0, 1'b1, 10'd0,    6'd0,  8'd0,   8'd0,   12'd2},
        '{1'b1, 1'b0, 10'd2,    6'd3,  8'd0,   8'd4,   12'd11},
        '{1'b1, 1'b0, 10'd5,    6'd0,  8'd3,   8'd0,   12'd10},
        '{1'b1, 1'b0, 10'd1023, 6'd63, 8'd255, 8'd255, 12'd1598}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       line_tick = 1'b0;
    logic       active_mode = 1'b0;
    logic       dual_panel = 1'b0;
    logic [9:0] lines_m1 = '0;
    logic [5:0] sync_m1 = '0;
    logic [7:0] eof_wait = '0;
    logic [7:0] bof_wait = '0;
    logic       frame_clk, line_clk_gate, line_valid, frame_done;
    logic [9:0] line_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lcd_vtiming_seq u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .line_tick(line_tick),
        .active_mode(active_mode), .dual_panel(dual_panel),
        .lines_m1(lines_m1), .sync_m1(sync_m1),
        .eof_wait(eof_wait), .bof_wait(bof_wait),
        .frame_clk(frame_clk), .line_clk_gate(line_clk_gate),
        .line_valid(line_valid), .line_idx(line_idx), .frame_done(frame_done)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk({tag, " frame_clk"}, int'(frame_clk), 0);
        chk({tag, " gate"}, int'(line_clk_gate), 0);
        chk({tag, " valid"}, int'(line_valid), 0);
        chk({tag, " idx"}, int'(line_idx), 0);
        chk({tag, " done"}, int'(frame_done), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Expected outputs for line period j after frame start.
    task automatic expect_at(input row_t r, input int j,
                             output int e_fclk, output int e_gate,
                             output int e_val, output int e_idx, output int e_eof);
        int b, d, e, v, f, p, pp;
        d = int'(r.lpp) + 1;
        v = int'(r.vsw) + 1;
        b = r.act ? int'(r.bfw) : 0;
        e = r.act ? int'(r.efw) : 0;
        f = b + d + e + v;
        p = j % f;
        e_fclk = 0; e_gate = 0; e_val = 0; e_idx = 0;
        if (r.act) begin
            e_gate = 1;
            if (p >= b && p < b + d) begin e_val = 1; e_idx = p - b; end
            else if (p >= b + d + e) e_fclk = 1;
        end else if (p < d) begin
            e_gate = 1; e_val = 1; e_idx = p; e_fclk = (p == 0) ? 1 : 0;
        end
        pp = (j - 1) % f;
        e_eof = (j >= 1 && pp == b + d - 1) ? 1 : 0;
    endtask

    task automatic load_row(input row_t r);
        active_mode = r.act; dual_panel = r.dual; lines_m1 = r.lpp;
        sync_m1 = r.vsw; eof_wait = r.efw; bof_wait = r.bfw;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run completion)");
            finish_run();
        end
    end

    initial begin
        int fc, gt, vl, ix, ef, last_eof;
        string ta, tb;
        // Reset state.
        repeat (3) @(negedge clk);
        chk_quiet("R7 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R7 after reset");

        for (int r = 0; r < NROW; r++) begin
            row_t rw;
            int nt;
            rw = TAB[r];
            nt = 2 * int'(rw.flen) + 1;
            load_row(rw);
            en = 1'b1;
            @(negedge clk);
            // R6: perturb every field while enabled.
            active_mode = ~rw.act; dual_panel = ~rw.dual; lines_m1 = ~rw.lpp;
            sync_m1 = ~rw.vsw; eof_wait = ~rw.efw; bof_wait = ~rw.bfw;
            @(negedge clk);
            chk_quiet("R7 armed");
            ta = rw.act ? "R2" : "R5";
            tb = rw.act ? "R3" : "R4";
            last_eof = -1;
            for (int j = 0; j < nt; j++) begin
                line_tick = 1'b1;
                @(negedge clk);
                line_tick = 1'b0;
                expect_at(rw, j, fc, gt, vl, ix, ef);
                chk({ta, " frame_clk R6 R9 R10"}, int'(frame_clk), fc);
                chk({tb, " line_clk_gate"}, int'(line_clk_gate), gt);
                chk("R1 line_valid", int'(line_valid), vl);
                chk("R1 line_idx", int'(line_idx), ix);
                chk("R8 frame_done", int'(frame_done), ef);
                if (frame_done) begin
                    if (last_eof >= 0) chk("R8 frame length", j - last_eof, int'(rw.flen));
                    last_eof = j;
                end
                @(negedge clk);
                chk("R8 strobe width", int'(frame_done), 0);
                @(negedge clk);
            end
            if (r == 0) begin
                // R7: disable in the same cycle as a tick.
                line_tick = 1'b1;
                en = 1'b0;
                @(negedge clk);
                line_tick = 1'b0;
                chk_quiet("R7 disable with tick");
            end else begin
                en = 1'b0;
                @(negedge clk);
                chk_quiet("R7 disable");
            end
            // R7: ticks while disabled leave outputs idle.
            line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
            @(negedge clk);
            chk_quiet("R7 idle tick");
        end
        done = 1'b1;
        finish_run();
    end

endmodule